// File: doc/BRIEF.md
# Single-Cycle 16-bit Register-to-Register Execution Datapath

This block executes one arithmetic, logic or shift instruction per clock. A 16-bit instruction word is decoded combinationally. Two registers are read from a 16-entry register file, the ALU (which contains a logarithmic barrel shifter) computes a result, and the result is written back at the next rising edge. The upper four bits hold the opcode. Bits 11:8 always name the destination and bits 7:4 name the first source. Bits 3:0 name either the second source register or, for shift-class opcodes, an unsigned shift distance.

A mode pin chooses between two phases. In the load phase the datapath ignores instructions, and a separate load port (enable, address, data) writes register contents directly. In the execute phase the load port is ignored, and ALU results are written to the register file. Every cycle, a write-back report (`wb_valid`, `wb_addr`, `wb_data`) shows the write that the coming edge will commit. It is a combinational result of the present inputs and register contents.

Instruction intake follows a valid/ready rule. `instr_ready` is high exactly while the execute phase is selected. An instruction is consumed at a rising edge where both `instr_valid` and `instr_ready` are high. While `instr_ready` is low, the source must hold its word, because nothing is consumed. The block never stalls in the execute phase. The write-back report has no ready input: it is a status view, and a listener must take it every cycle.

Top module: `alu_datapath_top`

## Requirements
- R1: An active-low reset clears all 16 registers to zero.
- R2: With `run_mode`=0, `instr_ready` is low and instruction inputs have no effect. When `load_we`=1, `load_data` is written to register `load_addr` at the next edge and reported on the write-back port in the same cycle. When `load_we`=0, nothing is written.
- R3: With `run_mode`=1, `instr_ready` is high and the load port has no effect. A cycle with `instr_valid`=0 writes nothing and leaves `wb_valid` low.
- R4: Opcode 0000 writes R[11:8] = R[7:4] + R[3:0], and opcode 0001 writes R[11:8] = R[7:4] - R[3:0], both modulo 2^16.
- R5: Opcode 0010 writes the bitwise AND of R[7:4] and R[3:0] to R[11:8], and opcode 0011 writes their bitwise OR.
- R6: Opcode 0100 shifts R[7:4] left by the unsigned amount in bits 3:0, filling with zeros, and writes the result to R[11:8].
- R7: Opcode 0101 shifts R[7:4] right by bits 3:0, filling with zeros.
- R8: Opcode 0110 shifts R[7:4] right by bits 3:0, filling with copies of bit 15.
- R9: Opcode 0111 rotates R[7:4] left by bits 3:0. Bits leaving at bit 15 re-enter at bit 0.
- R10: Opcodes 1000 through 1111 leave `wb_valid` low and change no register.
- R11: Register reads are combinational and writes land at the rising edge. A value written in one cycle is read by the next instruction. An instruction whose source is also its destination reads the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 0 selects the load phase, 1 the execute phase |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Instruction accepted this cycle when valid |
| instr | input | 16 | Instruction word |
| load_we | input | 1 | Load-phase write enable |
| load_addr | input | 4 | Load-phase register index |
| load_data | input | 16 | Load-phase write value |
| wb_valid | output | 1 | A register write commits at the next edge |
| wb_addr | output | 4 | Register being written |
| wb_data | output | 16 | Value being written |

## Verification
The bench builds the block with its default widths: 16-bit data and 16 registers. This makes every shift distance from 0 to 15 and every register index reachable from the 4-bit fields. Directed cases cover the shift-distance edges 0, 1, 8 and 15, sign fill on both signs, rotation carrying bit 15 into bit 0, and the eight unused opcodes. A later reread shows that each unused opcode left its named destination unchanged. A long stretch of random instructions over preloaded registers then runs against a behavioural model, so that chains of dependent instructions are exercised.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_SLL = 3'd4,
    FN_SRL = 3'd5,
    FN_SRA = 3'd6,
    FN_ROL = 3'd7
  } alu_fn_e;

  localparam int FIELD_W = 4;
  localparam int INSTR_W = 16;

  typedef struct packed {
    logic               writes;
    alu_fn_e            fn;
    logic [FIELD_W-1:0] dst;
    logic [FIELD_W-1:0] src_a;
    logic [FIELD_W-1:0] low_field;
  } dec_t;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec.writes    = ~instr[15];
    dec.fn        = alu_fn_e'(instr[14:12]);
    dec.dst       = instr[11:8];
    dec.src_a     = instr[7:4];
    dec.low_field = instr[3:0];
  end
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
  parameter int W = 16
) (
  input  logic [W-1:0]         data,
  input  logic [$clog2(W)-1:0] amt,
  input  logic                 to_right,
  input  logic                 arith,
  input  logic                 rotate,
  output logic [W-1:0]         result
);
  localparam int SHW = $clog2(W);

  logic [SHW:0][W-1:0] stg;
  logic                sign_fill;

  assign sign_fill = arith & data[W-1];
  assign stg[0]    = data;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [W-1:0] go_left;
    logic [W-1:0] go_right;
    logic [D-1:0] left_in;
    logic [D-1:0] right_in;

    assign left_in  = rotate ? stg[i][W-1:W-D] : '0;
    assign right_in = rotate ? stg[i][D-1:0] : {D{sign_fill}};
    assign go_left  = {stg[i][W-1-D:0], left_in};
    assign go_right = {right_in, stg[i][W-1:D]};
    assign stg[i+1] = amt[i] ? (to_right ? go_right : go_left) : stg[i];
  end

  assign result = stg[SHW];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_fn_e            fn,
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic [FIELD_W-1:0] imm,
  output logic [W-1:0]       y
);
  localparam int SHW = $clog2(W);

  logic [W-1:0]   sh_out;
  logic [SHW-1:0] amt;
  logic           to_right;
  logic           arith;
  logic           rotate;

  assign amt      = SHW'(imm);
  assign to_right = (fn == FN_SRL) || (fn == FN_SRA);
  assign arith    = (fn == FN_SRA);
  assign rotate   = (fn == FN_ROL);

  dp_shifter #(.W(W)) u_shift (
    .data     (a),
    .amt      (amt),
    .to_right (to_right),
    .arith    (arith),
    .rotate   (rotate),
    .result   (sh_out)
  );

  always_comb begin
    unique case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      default: y = sh_out;
    endcase
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int W     = 16,
  parameter int NREGS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(NREGS)-1:0] raddr_a,
  input  logic [$clog2(NREGS)-1:0] raddr_b,
  output logic [W-1:0]             rdata_a,
  output logic [W-1:0]             rdata_b
);
  logic [NREGS-1:0][W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/alu_datapath_top.sv
module alu_datapath_top
  import dp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREGS  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run_mode,
  input  logic                     instr_valid,
  output logic                     instr_ready,
  input  logic [INSTR_W-1:0]       instr,
  input  logic                     load_we,
  input  logic [$clog2(NREGS)-1:0] load_addr,
  input  logic [DATA_W-1:0]        load_data,
  output logic                     wb_valid,
  output logic [$clog2(NREGS)-1:0] wb_addr,
  output logic [DATA_W-1:0]        wb_data
);
  localparam int AW = $clog2(NREGS);

  dec_t              dec;
  logic [DATA_W-1:0] rs_val;
  logic [DATA_W-1:0] rt_val;
  logic [DATA_W-1:0] alu_y;
  logic              exec_we;

  dp_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  dp_regfile #(.W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wb_valid),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (AW'(dec.src_a)),
    .raddr_b (AW'(dec.low_field)),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  dp_alu #(.W(DATA_W)) u_alu (
    .fn  (dec.fn),
    .a   (rs_val),
    .b   (rt_val),
    .imm (dec.low_field),
    .y   (alu_y)
  );

  assign instr_ready = run_mode;
  assign exec_we     = instr_valid & dec.writes;

  always_comb begin
    if (run_mode) begin
      wb_valid = exec_we;
      wb_addr  = AW'(dec.dst);
      wb_data  = alu_y;
    end else begin
      wb_valid = load_we;
      wb_addr  = load_addr;
      wb_data  = load_data;
    end
  end
endmodule

// File: rtl/dp_datapath_chk.sv
module dp_datapath_chk #(
  parameter int DATA_W = 16,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_mode,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [15:0]       instr,
  input logic              wb_valid,
  input logic [AW-1:0]     wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic [DATA_W-1:0] src_a_val
);
  logic [DATA_W-1:0] one_w;
  assign one_w = {{(DATA_W-1){1'b0}}, 1'b1};

  // R2
  load_phase_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |-> !instr_ready);

  // R3
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && !instr_valid) |-> !wb_valid);

  // R10
  unused_op_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && instr_valid && instr[15]) |-> !wb_valid);

  // R6
  sll_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && instr_valid && instr[15:12] == 4'b0100)
      |-> ((wb_data & ((one_w << instr[3:0]) - one_w)) == '0));

  // R8
  sra_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && instr_valid && instr[15:12] == 4'b0110)
      |-> (wb_data[DATA_W-1] == src_a_val[DATA_W-1]));

  // R9
  rol_ones_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && instr_valid && instr[15:12] == 4'b0111)
      |-> ($countones(wb_data) == $countones(src_a_val)));

  // R11
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wb_valid) && run_mode && instr_valid
      && (AW'(instr[7:4]) == $past(wb_addr)))
      |-> (src_a_val == $past(wb_data)));
endmodule

bind alu_datapath_top dp_datapath_chk #(.DATA_W(DATA_W), .AW($clog2(NREGS))) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_mode    (run_mode),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .instr       (instr),
  .wb_valid    (wb_valid),
  .wb_addr     (wb_addr),
  .wb_data     (wb_data),
  .src_a_val   (rs_val)
);

// File: tb/tb_alu_datapath_top.sv
`timescale 1ns/1ps
module tb_alu_datapath_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_mode = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [15:0] instr = '0;
  logic        load_we = 1'b0;
  logic [3:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic        wb_valid;
  logic [3:0]  wb_addr;
  logic [15:0] wb_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [16];

  always #10 clk = ~clk;

  alu_datapath_top dut (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .instr_valid(instr_valid),
    .instr_ready(instr_ready), .instr(instr), .load_we(load_we),
    .load_addr(load_addr), .load_data(load_data), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_data(wb_data)
  );

  function automatic logic [15:0] ref_calc(logic [3:0] op, logic [15:0] a,
                                           logic [15:0] b, logic [3:0] sh);
    logic [15:0] r;
    case (op)
      4'd0: r = a + b;
      4'd1: r = a - b;
      4'd2: r = a & b;
      4'd3: r = a | b;
      4'd4: r = a << sh;
      4'd5: r = a >> sh;
      4'd6: r = 16'($signed(a) >>> sh);
      default: begin
        r = a;
        for (int k = 0; k < 16; k++) if (k < int'(sh)) r = {r[14:0], r[15]};
      end
    endcase
    return r;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic rm, logic v, logic [15:0] ins,
                      logic lwe, logic [3:0] la, logic [15:0] ld);
    logic       ev;
    logic [3:0] ea;
    logic [15:0] ed;
    run_mode = rm; instr_valid = v; instr = ins;
    load_we = lwe; load_addr = la; load_data = ld;
    if (!rm) begin
      ev = lwe; ea = la; ed = ld;
    end else begin
      ev = v && !ins[15];
      ea = ins[11:8];
      ed = ref_calc(ins[15:12], model[ins[7:4]], model[ins[3:0]], ins[3:0]);
    end
    @(negedge clk);
    check(tag, "instr_ready", int'(instr_ready), int'(rm));
    check(tag, "wb_valid", int'(wb_valid), int'(ev));
    if (ev) begin
      check(tag, "wb_addr", int'(wb_addr), int'(ea));
      check(tag, "wb_data", int'(wb_data), int'(ed));
    end
    @(posedge clk);
    if (ev) model[ea] = ed;
    #1;
  endtask

  task automatic op(string tag, logic [3:0] opc, logic [3:0] d,
                    logic [3:0] s, logic [3:0] t);
    step(tag, 1'b1, 1'b1, {opc, d, s, t}, 1'b0, 4'd0, 16'h0);
  endtask

  task automatic peek(string tag, logic [3:0] r);
    op(tag, 4'd4, r, r, 4'd0);
  endtask

  task automatic load(string tag, logic [3:0] r, logic [15:0] v);
    step(tag, 1'b0, 1'b0, 16'h0, 1'b1, r, v);
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: every register reads zero after reset
    for (int i = 0; i < 16; i++) peek("R1", 4'(i));
    // R2: load phase, with a bogus instruction present that must be ignored
    for (int i = 0; i < 16; i++)
      step("R2", 1'b0, 1'b1, 16'h0123, 1'b1, 4'(i), 16'(16'h1111 * i + 16'h0f0f));
    step("R2", 1'b0, 1'b1, 16'h0234, 1'b0, 4'd5, 16'hdead);
    peek("R2", 4'd5);
    load("R2", 4'd1, 16'h8000);
    load("R2", 4'd2, 16'h7fff);
    load("R2", 4'd3, 16'h0001);
    load("R2", 4'd4, 16'hf0f0);
    load("R2", 4'd6, 16'hb2c4);
    // R3: load port ignored in run phase; idle cycle writes nothing
    step("R3", 1'b1, 1'b0, 16'h0123, 1'b1, 4'd7, 16'hbeef);
    peek("R3", 4'd7);
    peek("R3", 4'd1);
    // R4
    op("R4", 4'd0, 4'd8, 4'd2, 4'd3);   // 7fff+1 = 8000
    op("R4", 4'd0, 4'd9, 4'd1, 4'd1);   // wrap to 0
    op("R4", 4'd1, 4'd10, 4'd0, 4'd3);  // 0f0f-1
    op("R4", 4'd1, 4'd11, 4'd9, 4'd3);  // 0-1 = ffff
    // R5
    op("R5", 4'd2, 4'd12, 4'd4, 4'd6);
    op("R5", 4'd3, 4'd13, 4'd4, 4'd3);
    // R6
    op("R6", 4'd4, 4'd14, 4'd1, 4'd1);  // 8000<<1 = 0
    op("R6", 4'd4, 4'd14, 4'd3, 4'd15);
    op("R6", 4'd4, 4'd14, 4'd6, 4'd8);
    // R7
    op("R7", 4'd5, 4'd14, 4'd1, 4'd15);
    op("R7", 4'd5, 4'd14, 4'd6, 4'd4);
    op("R7", 4'd5, 4'd14, 4'd6, 4'd0);
    // R8
    op("R8", 4'd6, 4'd14, 4'd1, 4'd4);  // f800
    op("R8", 4'd6, 4'd14, 4'd2, 4'd4);  // 07ff
    op("R8", 4'd6, 4'd14, 4'd1, 4'd15); // ffff
    // R9
    op("R9", 4'd7, 4'd14, 4'd1, 4'd1);  // 0001
    op("R9", 4'd7, 4'd14, 4'd6, 4'd8);
    op("R9", 4'd7, 4'd14, 4'd6, 4'd15);
    // R10: unused opcodes, then reread destination
    for (int k = 8; k < 16; k++) begin
      op("R10", 4'(k), 4'd2, 4'd0, 4'd1);
      peek("R10", 4'd2);
    end
    // R11: back-to-back dependency and in-place update
    op("R11", 4'd0, 4'd5, 4'd3, 4'd3);
    op("R11", 4'd0, 4'd5, 4'd5, 4'd5);
    op("R11", 4'd7, 4'd5, 4'd5, 4'd3);
    peek("R11", 4'd5);
    // R4 R5 R6 R7 R8 R9 R10 R11 random mix
    for (int n = 0; n < 400; n++)
      step("R11", 1'b1, 1'($urandom_range(0, 7) != 0), 16'($urandom), 1'b0, 4'd0, 16'h0);
    for (int i = 0; i < 16; i++) peek("R11", 4'(i));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule